// File: doc/BRIEF.md
# QCIF-to-NTSC Line-Repeat Sequencer

This block schedules vertical interpolation from a quarter-resolution source picture to an NTSC field without buffering any output lines. Output lines are produced in groups of ten. For each output line it names the stored source luma line and the stored source chroma line that head the filter window, and it selects the coefficient set the vertical filter applies to them. Each coefficient set holds seven taps. The filter arithmetic sits outside this block.

Ten output lines take six luma lines and three chroma lines. Luma lines are reused in a once-twice-twice order, and that order runs twice per group. Chroma lines are reused three, four and three times. Luma therefore needs five coefficient sets per field and chroma needs ten. A field-parity bit, captured when a field starts, moves both set indices into the upper half of their ranges for the second field.

A line strobe advances one output line. A field strobe returns the sequencer to the first line of a group with both source counters at zero.

Top module: `qcif_ntsc_line_seq`

## Requirements
- R1: After reset, all index outputs are 0, the captured parity is even and group_done is 0.
- R2: Within a group, output line k (k = 0..9) reads luma line base_l + {0,1,1,2,2,3,4,4,5,5}[k], where base_l is the group's luma base.
- R3: Within a group, output line k reads chroma line base_c + {0,0,0,1,1,1,1,2,2,2}[k], where base_c is the group's chroma base.
- R4: luma_cset equals (k mod 5) plus 5 when the captured parity is 1, so it spans 0..4 for an even field and 5..9 for an odd field.
- R5: chroma_cset equals k plus 10 when the captured parity is 1, so it spans 0..9 for an even field and 10..19 for an odd field.
- R6: The line strobe taken at k = 9 sets k to 0, adds 6 to base_l and 3 to base_c, and raises group_done for exactly the following cycle; group_done is 0 at all other times.
- R7: The field strobe sets k, base_l and base_c to 0, captures field_odd as the parity, and wins over a line strobe in the same cycle, in which case group_done stays 0.
- R8: field_odd has no effect on any output except when sampled together with the field strobe.
- R9: With neither strobe asserted, every output holds its value, apart from group_done falling after its one-cycle pulse.
- R10: Source line indices wrap modulo 2^LINE_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_stb | input | 1 | Advance to the next output line |
| field_stb | input | 1 | Start a new field |
| field_odd | input | 1 | Field parity, sampled with field_stb |
| luma_line | output | LINE_W | Source luma line index |
| chroma_line | output | LINE_W | Source chroma line index |
| luma_cset | output | 4 | Luma coefficient-set index, 0..9 |
| chroma_cset | output | 5 | Chroma coefficient-set index, 0..19 |
| group_done | output | 1 | One-cycle pulse after a group of ten lines completes |

## Verification
The group wrap and the field restart can land in the same cycle. The bench provokes this by driving both strobes together on the tenth line of a group, and again in the middle of a group. It expects the field restart to win: all counters return to zero, the newly captured parity shows in both set indices, and no group_done pulse appears.

// File: rtl/qcif_ntsc_line_seq.sv
module qcif_ntsc_line_seq #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              field_stb,
  input  logic              field_odd,
  output logic [LINE_W-1:0] luma_line,
  output logic [LINE_W-1:0] chroma_line,
  output logic [3:0]        luma_cset,
  output logic [4:0]        chroma_cset,
  output logic              group_done
);
  localparam logic [3:0] LAST_PHASE  = 4'd9;
  localparam logic [3:0] HALF_GROUP  = 4'd5;
  localparam int         LUMA_STEP   = 6;
  localparam int         CHROMA_STEP = 3;
  localparam logic [3:0] LUMA_ODD    = 4'd5;
  localparam logic [4:0] CHROMA_ODD  = 5'd10;

  logic [3:0]        phase;
  logic [LINE_W-1:0] lbase, cbase;
  logic              par;
  logic              half;
  logic [3:0]        sub;
  logic [2:0]        luma_off, chroma_off;
  logic              wrap;

  assign wrap = line_stb && !field_stb && (phase == LAST_PHASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= '0;
      lbase      <= '0;
      cbase      <= '0;
      par        <= 1'b0;
      group_done <= 1'b0;
    end else if (field_stb) begin
      phase      <= '0;
      lbase      <= '0;
      cbase      <= '0;
      par        <= field_odd;
      group_done <= 1'b0;
    end else if (line_stb) begin
      group_done <= wrap;
      if (wrap) begin
        phase <= '0;
        lbase <= lbase + LINE_W'(LUMA_STEP);
        cbase <= cbase + LINE_W'(CHROMA_STEP);
      end else begin
        phase <= phase + 4'd1;
      end
    end else begin
      group_done <= 1'b0;
    end
  end

  assign half = (phase >= HALF_GROUP);
  assign sub  = half ? (phase - HALF_GROUP) : phase;

  always_comb begin
    if (sub == 4'd0)      luma_off = 3'd0;
    else if (sub < 4'd3)  luma_off = 3'd1;
    else                  luma_off = 3'd2;
    if (half) luma_off = luma_off + 3'd3;
    if (phase < 4'd3)      chroma_off = 3'd0;
    else if (phase < 4'd7) chroma_off = 3'd1;
    else                   chroma_off = 3'd2;
  end

  assign luma_line   = lbase + LINE_W'(luma_off);
  assign chroma_line = cbase + LINE_W'(chroma_off);
  assign luma_cset   = sub + (par ? LUMA_ODD : 4'd0);
  assign chroma_cset = {1'b0, phase} + (par ? CHROMA_ODD : 5'd0);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST_PHASE);  // R2
  AST_LUMA_SET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    luma_cset <= 4'd9);  // R4
  AST_CHROMA_SET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chroma_cset <= 5'd19);  // R5
  AST_DONE_AT_GROUP_START: assert property (@(posedge clk) disable iff (!rst_n)
    group_done |-> (chroma_cset == (par ? 5'd10 : 5'd0)));  // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    group_done |=> !group_done || $past(line_stb));  // R6
  AST_FIELD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    field_stb |=> (luma_line == '0) && (chroma_line == '0) && !group_done);  // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_stb && !field_stb) |=> $stable(luma_line) && $stable(chroma_line)
      && $stable(luma_cset) && $stable(chroma_cset));  // R9
endmodule

// File: tb/tb_qcif_ntsc_line_seq.sv
module tb_qcif_ntsc_line_seq;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_stb = 1'b0, field_stb = 1'b0, field_odd = 1'b0;
  logic [LINE_W-1:0] luma_line, chroma_line;
  logic [3:0] luma_cset;
  logic [4:0] chroma_cset;
  logic group_done;

  qcif_ntsc_line_seq #(.LINE_W(LINE_W)) dut (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .field_stb(field_stb),
    .field_odd(field_odd), .luma_line(luma_line), .chroma_line(chroma_line),
    .luma_cset(luma_cset), .chroma_cset(chroma_cset), .group_done(group_done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m_k = 0, m_lb = 0, m_cb = 0, m_par = 0, m_done = 0;
  int luma_tab[10]   = '{0,1,1,2,2,3,4,4,5,5};
  int chroma_tab[10] = '{0,0,0,1,1,1,1,2,2,2};

  task automatic cmp(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_all(string ctx);
    cmp({"R2 luma_line ", ctx}, int'(luma_line), (m_lb + luma_tab[m_k]) % (1 << LINE_W));
    cmp({"R3 chroma_line ", ctx}, int'(chroma_line), (m_cb + chroma_tab[m_k]) % (1 << LINE_W));
    cmp({"R4 luma_cset ", ctx}, int'(luma_cset), (m_k % 5) + 5 * m_par);
    cmp({"R5 chroma_cset ", ctx}, int'(chroma_cset), m_k + 10 * m_par);
    cmp({"R6 group_done ", ctx}, int'(group_done), m_done);
  endtask

  task automatic model_line();
    if (m_k == 9) begin
      m_k = 0; m_lb += 6; m_cb += 3; m_done = 1;
    end else begin
      m_k++; m_done = 0;
    end
  endtask

  task automatic model_field(int odd);
    m_k = 0; m_lb = 0; m_cb = 0; m_par = odd; m_done = 0;
  endtask

  task automatic drive(logic l, logic f, logic odd);
    @(negedge clk);
    line_stb = l; field_stb = f; field_odd = odd;
    @(negedge clk);
    line_stb = 1'b0; field_stb = 1'b0;
    if (f) model_field(int'(odd));
    else if (l) model_line();
    else m_done = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_field(0);
    check_all("R1 reset state");
  endtask

  task automatic t_field(logic odd, int groups, string ctx);
    drive(1'b0, 1'b1, odd);
    check_all({ctx, " field start R7"});
    for (int i = 0; i < groups * 10; i++) begin
      drive(1'b1, 1'b0, odd);
      check_all(ctx);
      if (m_done == 1) begin
        drive(1'b0, 1'b0, odd);
        check_all({ctx, " done falls R6"});
      end
    end
  endtask

  task automatic t_parity_ignored();
    drive(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 12; i++) begin
      drive(1'b1, 1'b0, i[0]);
      check_all("R8 parity toggled mid-field");
    end
    drive(1'b0, 1'b0, 1'b1);
    check_all("R8 parity high while idle");
  endtask

  task automatic t_collision();
    drive(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 9; i++) drive(1'b1, 1'b0, 1'b0);
    check_all("R7 at last line");
    drive(1'b1, 1'b1, 1'b1);
    check_all("R7 both strobes at wrap");
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0);
    check_all("R7 both strobes mid-group");
  endtask

  task automatic t_idle_hold();
    drive(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 7; i++) drive(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      drive(1'b0, 1'b0, 1'b0);
      check_all("R9 idle hold");
    end
  endtask

  task automatic t_wrap();
    t_field(1'b0, 90, "R10 long run");
    cmp("R10 luma base after 90 groups", int'(luma_line), (90 * 6) % 512);
  endtask

  initial begin
    t_reset();
    t_field(1'b0, 2, "even field");
    t_field(1'b1, 2, "odd field");
    t_parity_ignored();
    t_collision();
    t_idle_hold();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end
endmodule